// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block reads a one-time-programmable fuse array one byte at a time. It also owns the power bring-up of the array. A power-on request walks the array through a fixed sequence. The first supply stage comes on, a programmable settling gap follows, then the second stage comes on. The isolation clamp between the fuse domain and the core is released after that, and finally the optional burst-mode enable is set. A power-off request runs the same steps in reverse, with the same gap before the first stage drops.

A read starts when the requester writes an address into the control word. That write also clears the ready flag. The fuse macro, modelled as a synchronous store with a fixed access latency, returns the byte. The block then raises ready and places the byte in the low eight bits of the control word. The requester polls ready and gives up on its own timeout. A one-bit bank field picks one of two fuse banks. A bank write that cannot take effect leaves the field unchanged and raises a busy indication.

Top module: `fuse_rd_seq`

## Requirements
- R1: After reset the two supply stages and burst-enable are low, isolation is high, ready and the busy indication are low, and the bank field reads 0.
- R2: A power-on request while powered down raises stage A. Stage B rises exactly GAP_CYC cycles after stage A. Isolation drops one cycle after stage B rises, and burst-enable (when BURST_USE is 1) rises one cycle after isolation drops. Only from that cycle on are reads accepted.
- R3: A power-off request while powered and idle clears burst-enable in the next cycle. Isolation rises one cycle after that, and stage B drops one cycle later. Stage A drops exactly GAP_CYC cycles after stage B.
- R4: An accepted control write loads the address into control-word bits [AW+7:8] and clears the ready flag, which is the top bit (AW+8). In the cycle after the write, ready reads 0 and the new address is visible.
- R5: When the array is powered, an accepted write is followed by ready rising exactly LAT+1 cycles after the write edge. At that point bits [7:0] hold the fuse byte, and each write yields exactly one ready.
- R6: The fuse byte at address a is (a*29 + 17) mod 256 in bank 0 and (a*29 + 101) mod 256 in bank 1. The bank used is the one held at the write.
- R7: A control write while the array is not fully powered and open still loads the address and clears ready. No read starts, and ready stays low.
- R8: A bank write while a read is in flight leaves the bank field unchanged and sets the busy indication. A bank write with no read in flight takes the new value and clears the busy indication.
- R9: A control write while a read is in flight is ignored. The address field is kept and the byte returned belongs to the first address.
- R10: A power-off request made while a read is in flight, or in the same cycle as an accepted write, is ignored. A power-on request while powered has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_req | input | 1 | One-cycle request to power the array up |
| pwr_off_req | input | 1 | One-cycle request to power the array down |
| ctl_wr | input | 1 | Control-word write strobe (starts a read) |
| ctl_addr | input | AW | Fuse byte address written with ctl_wr |
| bank_wr | input | 1 | Bank-field write strobe |
| bank_val | input | 1 | Requested bank |
| ctl_word | output | AW+9 | {ready, address, data byte} |
| bank_sel | output | 1 | Current bank field |
| bank_busy | output | 1 | Last bank write was refused |
| fuse_pwr_a | output | 1 | First supply stage enable |
| fuse_pwr_b | output | 1 | Second supply stage enable |
| fuse_iso | output | 1 | Isolation clamp, high = isolated |
| burst_en | output | 1 | Burst-mode enable to the fuse macro |

## Verification
The hardest situations to reach are the ones that need a read in flight at the same moment as another request. These are a bank change, a second control write and a power-off request. The window lasts only LAT+1 cycles. The bench therefore runs with a long access latency and issues the competing strobe on the cycle right after the write. It then reads the bank field, the address field and the power pins before the read completes. The power timing is captured by logging the first cycle each pin changes and comparing the differences.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    typedef enum logic [2:0] {
        PW_OFF,
        PW_UPGAP,
        PW_UPS2,
        PW_UPISO,
        PW_ON,
        PW_DNB,
        PW_DNISO,
        PW_DNGAP
    } pwr_state_e;

    localparam logic [15:0] FUSE_MUL   = 16'd29;
    localparam logic [7:0]  FUSE_SEED0 = 8'd17;
    localparam logic [7:0]  FUSE_SEED1 = 8'd101;

endpackage

// File: rtl/fuse_pwr_seq.sv
module fuse_pwr_seq
    import fuse_pkg::*;
#(
    parameter int GAP_CYC   = 200000,
    parameter bit BURST_USE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on_req,
    input  logic off_req,
    input  logic hold,
    output logic pwr_a,
    output logic pwr_b,
    output logic iso,
    output logic burst,
    output logic open
);
    localparam int CNT_W = $clog2(GAP_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GAP_CYC - 1);

    typedef struct packed {
        pwr_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             pa;
        logic             pb;
        logic             iso;
        logic             burst;
    } pwr_reg_t;

    pwr_reg_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            PW_OFF: if (on_req) begin
                d.pa  = 1'b1;
                d.cnt = '0;
                d.st  = PW_UPGAP;
            end
            PW_UPGAP: begin
                if (q.cnt == CNT_LAST) begin
                    d.pb = 1'b1;
                    d.st = PW_UPS2;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PW_UPS2: begin
                d.iso = 1'b0;
                d.st  = PW_UPISO;
            end
            PW_UPISO: begin
                d.burst = BURST_USE;
                d.st    = PW_ON;
            end
            PW_ON: if (off_req && !hold) begin
                d.burst = 1'b0;
                d.st    = PW_DNB;
            end
            PW_DNB: begin
                d.iso = 1'b1;
                d.st  = PW_DNISO;
            end
            PW_DNISO: begin
                d.pb  = 1'b0;
                d.cnt = '0;
                d.st  = PW_DNGAP;
            end
            PW_DNGAP: begin
                if (q.cnt == CNT_LAST) begin
                    d.pa = 1'b0;
                    d.st = PW_OFF;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = PW_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: PW_OFF, cnt: '0, pa: 1'b0, pb: 1'b0, iso: 1'b1, burst: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign pwr_a = q.pa;
    assign pwr_b = q.pb;
    assign iso   = q.iso;
    assign burst = q.burst;
    assign open  = (q.st == PW_ON);

    p_b_needs_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_b |-> pwr_a);
    p_open_needs_power_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !iso |-> (pwr_a && pwr_b));
    p_burst_needs_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        burst |-> !iso);
    p_a_drops_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_a) |-> (!pwr_b && iso));
endmodule

// File: rtl/fuse_macro_model.sv
module fuse_macro_model
    import fuse_pkg::*;
#(
    parameter int AW  = 10,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr,
    input  logic          bank,
    output logic          vld,
    output logic [7:0]    dat
);
    localparam int LAT_W = $clog2(LAT + 1);
    localparam logic [LAT_W-1:0] LAT_LOAD = LAT_W'(LAT - 1);

    typedef struct packed {
        logic             busy;
        logic [LAT_W-1:0] cnt;
        logic [AW-1:0]    addr;
        logic             bank;
        logic             vld;
        logic [7:0]       dat;
    } mac_reg_t;

    mac_reg_t q, d;
    logic [15:0] prod;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        prod  = 16'(q.addr) * FUSE_MUL;
        if (start && !q.busy) begin
            d.busy = 1'b1;
            d.cnt  = LAT_LOAD;
            d.addr = addr;
            d.bank = bank;
        end else if (q.busy) begin
            if (q.cnt == '0) begin
                d.busy = 1'b0;
                d.vld  = 1'b1;
                d.dat  = prod[7:0] + (q.bank ? FUSE_SEED1 : FUSE_SEED0);
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign vld = q.vld;
    assign dat = q.dat;

    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !q.busy);
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
    import fuse_pkg::*;
#(
    parameter int AW        = 10,
    parameter int LAT       = 3,
    parameter int GAP_CYC   = 200000,
    parameter bit BURST_USE = 1'b1,
    localparam int CW       = AW + 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_on_req,
    input  logic          pwr_off_req,
    input  logic          ctl_wr,
    input  logic [AW-1:0] ctl_addr,
    input  logic          bank_wr,
    input  logic          bank_val,
    output logic [CW-1:0] ctl_word,
    output logic          bank_sel,
    output logic          bank_busy,
    output logic          fuse_pwr_a,
    output logic          fuse_pwr_b,
    output logic          fuse_iso,
    output logic          burst_en
);
    typedef struct packed {
        logic          ready;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic          busy;
        logic          bank;
        logic          bank_busy;
    } ctl_reg_t;

    ctl_reg_t   q, d;
    logic       open;
    logic       mac_start;
    logic       mac_vld;
    logic [7:0] mac_dat;

    fuse_pwr_seq #(
        .GAP_CYC  (GAP_CYC),
        .BURST_USE(BURST_USE)
    ) i_pwr (
        .clk    (clk),
        .rst_n  (rst_n),
        .on_req (pwr_on_req),
        .off_req(pwr_off_req),
        .hold   (q.busy | ctl_wr),
        .pwr_a  (fuse_pwr_a),
        .pwr_b  (fuse_pwr_b),
        .iso    (fuse_iso),
        .burst  (burst_en),
        .open   (open)
    );

    fuse_macro_model #(
        .AW (AW),
        .LAT(LAT)
    ) i_mac (
        .clk  (clk),
        .rst_n(rst_n),
        .start(mac_start),
        .addr (ctl_addr),
        .bank (q.bank),
        .vld  (mac_vld),
        .dat  (mac_dat)
    );

    assign mac_start = ctl_wr && !q.busy && open;

    always_comb begin
        d = q;
        if (ctl_wr && !q.busy) begin
            d.addr  = ctl_addr;
            d.ready = 1'b0;
            d.busy  = open;
        end
        if (mac_vld && q.busy) begin
            d.data  = mac_dat;
            d.ready = 1'b1;
            d.busy  = 1'b0;
        end
        if (bank_wr) begin
            if (q.busy) begin
                d.bank_busy = 1'b1;
            end else begin
                d.bank      = bank_val;
                d.bank_busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ctl_word  = {q.ready, q.addr, q.data};
    assign bank_sel  = q.bank;
    assign bank_busy = q.bank_busy;

    p_ready_from_macro_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_word[CW-1]) |-> $past(mac_vld));
    p_closed_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mac_start |-> !fuse_iso);
    p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && bank_wr) |=> ($stable(bank_sel) && bank_busy));
    p_addr_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && ctl_wr) |=> $stable(ctl_word[CW-2:8]));
    p_open_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (open && !fuse_iso));
endmodule

// File: tb/test_fuse_rd_seq.sv
`timescale 1ns/1ps
module test_fuse_rd_seq;
    localparam int AW  = 10;
    localparam int LAT = 6;
    localparam int GAP = 16;
    localparam int CW  = AW + 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_on_req = 1'b0, pwr_off_req = 1'b0;
    logic ctl_wr = 1'b0;
    logic [AW-1:0] ctl_addr = '0;
    logic bank_wr = 1'b0, bank_val = 1'b0;
    logic [CW-1:0] ctl_word;
    logic bank_sel, bank_busy, fuse_pwr_a, fuse_pwr_b, fuse_iso, burst_en;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit bank_m = 1'b0;
    logic [CW-1:0] exp_word[$];
    int            exp_cyc[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fuse_rd_seq #(.AW(AW), .LAT(LAT), .GAP_CYC(GAP), .BURST_USE(1'b1)) i_fuse_rd_seq (
        .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
        .ctl_wr(ctl_wr), .ctl_addr(ctl_addr), .bank_wr(bank_wr), .bank_val(bank_val),
        .ctl_word(ctl_word), .bank_sel(bank_sel), .bank_busy(bank_busy),
        .fuse_pwr_a(fuse_pwr_a), .fuse_pwr_b(fuse_pwr_b), .fuse_iso(fuse_iso),
        .burst_en(burst_en)
    );

    function automatic logic [7:0] fuse_val(input int a, input bit b);
        return 8'((a * 29 + (b ? 101 : 17)) % 256);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: launch a read and push the expected result
    task automatic do_read(input int a);
        exp_word.push_back({1'b1, AW'(a), fuse_val(a, bank_m)});
        exp_cyc.push_back(cyc + LAT + 2);
        ctl_wr = 1'b1; ctl_addr = AW'(a);
        @(negedge clk);
        ctl_wr = 1'b0;
        check(ctl_word[CW-1] == 1'b0, "R4 ready cleared", ctl_word[CW-1], 0);
        check(ctl_word[CW-2:8] == AW'(a), "R4 address field", ctl_word[CW-2:8], a);
    endtask

    // monitor: every rising ready must match the head of the queue
    initial begin
        bit prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && ctl_word[CW-1] && !prev) begin
                if (exp_word.size() == 0) begin
                    check(1'b0, "R5/R7 unexpected ready", ctl_word, 0);
                end else begin
                    logic [CW-1:0] w;
                    int c;
                    w = exp_word.pop_front();
                    c = exp_cyc.pop_front();
                    check(ctl_word == w, "R5/R6 returned word", ctl_word, w);
                    check(cyc == c, "R5 ready latency", cyc, c);
                end
            end
            prev = rst_n && ctl_word[CW-1];
        end
    end

    initial begin
        #(5ns * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int t_a, t_b, t_i, t_u, k0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1
        check({fuse_pwr_a, fuse_pwr_b, burst_en} == 3'b000, "R1 supplies/burst", {fuse_pwr_a, fuse_pwr_b, burst_en}, 0);
        check(fuse_iso == 1'b1, "R1 isolation", fuse_iso, 1);
        check({ctl_word[CW-1], bank_sel, bank_busy} == 3'b000, "R1 ready/bank", {ctl_word[CW-1], bank_sel, bank_busy}, 0);

        // R7: write while unpowered
        ctl_wr = 1'b1; ctl_addr = AW'(10'h055);
        tick(1);
        ctl_wr = 1'b0;
        check(ctl_word[CW-2:8] == AW'(10'h055), "R7 address loaded", ctl_word[CW-2:8], 10'h055);
        tick(LAT + 4);
        check(ctl_word[CW-1] == 1'b0, "R7 ready stays low", ctl_word[CW-1], 0);

        // R2: power up
        k0 = cyc; t_a = -1; t_b = -1; t_i = -1; t_u = -1;
        pwr_on_req = 1'b1;
        for (int i = 0; i < GAP + 8; i++) begin
            @(negedge clk);
            pwr_on_req = 1'b0;
            if (fuse_pwr_a && t_a < 0) t_a = cyc;
            if (fuse_pwr_b && t_b < 0) t_b = cyc;
            if (!fuse_iso && t_i < 0) t_i = cyc;
            if (burst_en && t_u < 0) t_u = cyc;
        end
        check(t_a == k0 + 1, "R2 stage A rise", t_a, k0 + 1);
        check(t_b - t_a == GAP, "R2 gap A to B", t_b - t_a, GAP);
        check(t_i - t_b == 1, "R2 isolation release", t_i - t_b, 1);
        check(t_u - t_i == 1, "R2 burst after open", t_u - t_i, 1);

        // R5/R6 reads in bank 0
        do_read(0);        tick(LAT + 2);
        do_read(10'h3FF);  tick(LAT + 2);
        do_read(10'h123);  tick(LAT + 2);

        // R9: second write during a read
        do_read(10'h0AA);
        ctl_wr = 1'b1; ctl_addr = AW'(10'h0BB);
        tick(1);
        ctl_wr = 1'b0;
        check(ctl_word[CW-2:8] == AW'(10'h0AA), "R9 address kept", ctl_word[CW-2:8], 10'h0AA);
        tick(LAT + 2);

        // R8: bank write during a read refused
        do_read(10'h010);
        bank_wr = 1'b1; bank_val = 1'b1;
        tick(1);
        bank_wr = 1'b0;
        check(bank_sel == 1'b0, "R8 bank unchanged", bank_sel, 0);
        check(bank_busy == 1'b1, "R8 busy raised", bank_busy, 1);
        tick(LAT + 2);
        bank_wr = 1'b1; bank_val = 1'b1;
        tick(1);
        bank_wr = 1'b0; bank_m = 1'b1;
        check(bank_sel == 1'b1, "R8 bank taken", bank_sel, 1);
        check(bank_busy == 1'b0, "R8 busy cleared", bank_busy, 0);

        // R6: bank 1 content
        do_read(10'h010);  tick(LAT + 2);
        do_read(10'h2F0);  tick(LAT + 2);

        // R10: power-off during read, power-on while on
        do_read(10'h077);
        pwr_off_req = 1'b1;
        tick(1);
        pwr_off_req = 1'b0;
        tick(1);
        check({burst_en, fuse_iso} == 2'b10, "R10 off ignored in flight", {burst_en, fuse_iso}, 2'b10);
        tick(LAT + 2);
        pwr_on_req = 1'b1;
        tick(1);
        pwr_on_req = 1'b0;
        tick(2);
        check({fuse_pwr_a, fuse_pwr_b, fuse_iso, burst_en} == 4'b1101, "R10 on while on",
              {fuse_pwr_a, fuse_pwr_b, fuse_iso, burst_en}, 4'b1101);

        // R3: power down
        k0 = cyc; t_a = -1; t_b = -1; t_i = -1; t_u = -1;
        pwr_off_req = 1'b1;
        for (int i = 0; i < GAP + 8; i++) begin
            @(negedge clk);
            pwr_off_req = 1'b0;
            if (!burst_en && t_u < 0) t_u = cyc;
            if (fuse_iso && t_i < 0) t_i = cyc;
            if (!fuse_pwr_b && t_b < 0) t_b = cyc;
            if (!fuse_pwr_a && t_a < 0) t_a = cyc;
        end
        check(t_u == k0 + 1, "R3 burst drops first", t_u, k0 + 1);
        check(t_i - t_u == 1, "R3 isolation reasserted", t_i - t_u, 1);
        check(t_b - t_i == 1, "R3 stage B drop", t_b - t_i, 1);
        check(t_a - t_b == GAP, "R3 gap B to A", t_a - t_b, GAP);

        // R7 again after power-down
        ctl_wr = 1'b1; ctl_addr = AW'(10'h111);
        tick(1);
        ctl_wr = 1'b0;
        tick(LAT + 4);
        check(ctl_word[CW-1] == 1'b0, "R7 no read when off", ctl_word[CW-1], 0);
        check(exp_word.size() == 0, "R5 every read answered", exp_word.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule